// File: doc/BRIEF.md
# Dual-Rail Threshold-Gate Ripple Adder

This block adds two 4-bit operands and a carry-in. All of them arrive on dual-rail wire pairs, and the block returns a 4-bit sum and a carry-out in the same encoding. It uses no single-rail Boolean logic. Every bit is produced by threshold gates with hysteresis. A gate's output rises once enough of its inputs are high. It falls only after all of its inputs have dropped, and in every other case it holds its value. Each stage has two carry gates that fire when two of their three inputs are high, and two sum gates that fire when three of their five inputs are high. The stages are chained so the carry ripples from bit 0 to bit 3.

Each gate is modelled as a state bit that is updated once per clock step. One clock period therefore stands for one gate delay. This keeps the block synthesizable while keeping its delay-insensitive behaviour. Operation alternates between DATA wavefronts and NULL spacers. A small state machine with two states watches the output pairs and drives a completion flag. In state CMP_EMPTY the flag is low, and the machine moves to CMP_FULL when every output pair holds DATA. In state CMP_FULL the flag is high, and the machine returns to CMP_EMPTY when every output pair is NULL. While the outputs are only partly settled, the machine stays in its current state. The time to complete depends on the data: carries that a stage generates or kills locally settle early, and carries that must propagate through several stages settle late.

Top module: `ncl_ripple_adder`

## Requirements
- R1: For every pair, the true rail high with the false rail low means 1, the false rail high with the true rail low means 0, and both rails low means NULL. After reset every output rail and `done` are low.
- R2: When all inputs hold DATA, the decoded `sum` and `cout` equal a + b + cin.
- R3: No output pair ever has both of its rails high while the inputs are legal.
- R4: An output rail that is high stays high until every input of its gate is low. A partial NULL on the inputs clears no output. A partial DATA that meets no gate threshold raises no output rail.
- R5: `done` rises one step after every output pair holds DATA, and falls one step after every output pair is NULL. Otherwise it holds.
- R6: With a = 0, b = 0 and cin = 0 applied after a NULL spacer, `done` is first high after the 3rd clock edge.
- R7: With a = 15, b = 1 and cin = 0 applied after a NULL spacer, the carry ripples through all stages and `done` is first high after the 6th clock edge (WIDTH + 2).
- R8: After NULL is applied to all inputs, every output rail is low and `done` is low no later than WIDTH + 2 edges later. For a = 15, b = 1 this takes exactly 6 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Gate-delay step |
| rst_n | input | 1 | Asynchronous active-low reset; drives all gates to NULL |
| a_t | input | 4 | Operand A, true rails |
| a_f | input | 4 | Operand A, false rails |
| b_t | input | 4 | Operand B, true rails |
| b_f | input | 4 | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| sum_t | output | 4 | Sum, true rails |
| sum_f | output | 4 | Sum, false rails |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |
| done | output | 1 | Completion flag with hysteresis |

## Verification
The hardest behaviour to reach from the ports is gate hysteresis. It only appears when the inputs are half-way between wavefronts. The stimulus creates this state on purpose in two ways. First, it withdraws only operand A after a completed word and confirms that the outputs and `done` do not move. Second, it presents operand A alone after a spacer and confirms that nothing fires. The two latency extremes, 0+0 and 15+1, are timed edge by edge to show the early-settling carry path and the full ripple. An exhaustive sweep of all 512 DATA words then checks the sum and the rail exclusivity.

// File: rtl/ncl_pkg.sv
package ncl_pkg;
    typedef enum logic {
        CMP_EMPTY = 1'b0,
        CMP_FULL  = 1'b1
    } cmp_state_e;

    localparam int CARRY_M = 2;
    localparam int CARRY_N = 3;
    localparam int SUM_M   = 3;
    localparam int SUM_N   = 5;
endpackage

// File: rtl/ncl_th_gate.sv
// Threshold gate with hysteresis: rises at M of N inputs high,
// falls only when all inputs are low, otherwise keeps its state.
module ncl_th_gate #(
    parameter int M = 2,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic         q
);
    logic fire;
    logic clear;

    always_comb begin
        fire  = ($countones(din) >= M);
        clear = (din == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (fire)
            q <= 1'b1;
        else if (clear)
            q <= 1'b0;
    end
endmodule

// File: rtl/ncl_full_adder.sv
// One dual-rail stage: two 2-of-3 carry gates, two 3-of-5 sum gates.
// The stage's own carry rail enters each sum gate twice (weight two).
module ncl_full_adder
    import ncl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_t,
    input  logic x_f,
    input  logic y_t,
    input  logic y_f,
    input  logic ci_t,
    input  logic ci_f,
    output logic s_t,
    output logic s_f,
    output logic co_t,
    output logic co_f
);
    ncl_th_gate #(.M(CARRY_M), .N(CARRY_N)) u_co_t (
        .clk(clk), .rst_n(rst_n), .din({x_t, y_t, ci_t}), .q(co_t)
    );
    ncl_th_gate #(.M(CARRY_M), .N(CARRY_N)) u_co_f (
        .clk(clk), .rst_n(rst_n), .din({x_f, y_f, ci_f}), .q(co_f)
    );
    ncl_th_gate #(.M(SUM_M), .N(SUM_N)) u_s_t (
        .clk(clk), .rst_n(rst_n), .din({co_f, co_f, x_t, y_t, ci_t}), .q(s_t)
    );
    ncl_th_gate #(.M(SUM_M), .N(SUM_N)) u_s_f (
        .clk(clk), .rst_n(rst_n), .din({co_t, co_t, x_f, y_f, ci_f}), .q(s_f)
    );
endmodule

// File: rtl/ncl_completion.sv
// Completion detector as a two-state machine with hysteresis.
module ncl_completion
    import ncl_pkg::*;
#(
    parameter int PAIRS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PAIRS-1:0] rail_t,
    input  logic [PAIRS-1:0] rail_f,
    output logic             done
);
    cmp_state_e state, state_nx;
    logic all_data;
    logic all_null;

    always_comb begin
        all_data = &(rail_t | rail_f);
        all_null = ((rail_t | rail_f) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CMP_EMPTY;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CMP_EMPTY: if (all_data) state_nx = CMP_FULL;
            CMP_FULL:  if (all_null) state_nx = CMP_EMPTY;
        endcase
    end

    always_comb begin
        done = (state == CMP_FULL);
    end
endmodule

// File: rtl/ncl_ripple_adder.sv
module ncl_ripple_adder
    import ncl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] a_f,
    input  logic [WIDTH-1:0] b_t,
    input  logic [WIDTH-1:0] b_f,
    input  logic             cin_t,
    input  logic             cin_f,
    output logic [WIDTH-1:0] sum_t,
    output logic [WIDTH-1:0] sum_f,
    output logic             cout_t,
    output logic             cout_f,
    output logic             done
);
    localparam int PAIRS = WIDTH + 1;

    logic [WIDTH:0] cy_t;
    logic [WIDTH:0] cy_f;

    assign cy_t[0] = cin_t;
    assign cy_f[0] = cin_f;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        ncl_full_adder u_fa (
            .clk  (clk),
            .rst_n(rst_n),
            .x_t  (a_t[i]),
            .x_f  (a_f[i]),
            .y_t  (b_t[i]),
            .y_f  (b_f[i]),
            .ci_t (cy_t[i]),
            .ci_f (cy_f[i]),
            .s_t  (sum_t[i]),
            .s_f  (sum_f[i]),
            .co_t (cy_t[i+1]),
            .co_f (cy_f[i+1])
        );
    end

    assign cout_t = cy_t[WIDTH];
    assign cout_f = cy_f[WIDTH];

    ncl_completion #(.PAIRS(PAIRS)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .rail_t({cout_t, sum_t}),
        .rail_f({cout_f, sum_f}),
        .done  (done)
    );
endmodule

// File: rtl/ncl_ripple_adder_chk.sv
module ncl_ripple_adder_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_t,
    input logic [WIDTH-1:0] a_f,
    input logic [WIDTH-1:0] b_t,
    input logic [WIDTH-1:0] b_f,
    input logic             cin_t,
    input logic             cin_f,
    input logic [WIDTH-1:0] sum_t,
    input logic [WIDTH-1:0] sum_f,
    input logic             cout_t,
    input logic             cout_f,
    input logic             done
);
    logic out_data;
    logic out_null;
    assign out_data = &({cout_t, sum_t} | {cout_f, sum_f});
    assign out_null = (({cout_t, sum_t} | {cout_f, sum_f}) == '0);

    AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_t & sum_f) == '0) && !(cout_t && cout_f)); // R3

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_data)); // R5

    AST_DONE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(out_null)); // R5

    AST_COUT_T_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cout_t) |-> $past(!a_t[WIDTH-1] && !b_t[WIDTH-1])); // R4

    AST_COUT_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cout_f) |-> $past(!a_f[WIDTH-1] && !b_f[WIDTH-1])); // R4

    AST_SUM0_T_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sum_t[0]) |-> $past(!a_t[0] && !b_t[0] && !cin_t)); // R4

    AST_SUM0_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sum_f[0]) |-> $past(!a_f[0] && !b_f[0] && !cin_f)); // R4
endmodule

bind ncl_ripple_adder ncl_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f),
    .sum_t(sum_t), .sum_f(sum_f),
    .cout_t(cout_t), .cout_f(cout_f),
    .done(done)
);

// File: tb/ncl_ripple_adder_bench.sv
`timescale 1ns/1ps
module ncl_ripple_adder_bench;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
    logic cin_t = 1'b0, cin_f = 1'b0;
    logic [W-1:0] sum_t, sum_f;
    logic cout_t, cout_f, done;

    always #10 clk = ~clk;

    ncl_ripple_adder #(.WIDTH(W)) u_ncl_ripple_adder (
        .clk(clk), .rst_n(rst_n),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .cin_t(cin_t), .cin_f(cin_f),
        .sum_t(sum_t), .sum_f(sum_f),
        .cout_t(cout_t), .cout_f(cout_f),
        .done(done)
    );

    int checks = 0;
    int errors = 0;
    logic [W:0] exp_q[$];
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit outs_null();
        return ({cout_t, sum_t, cout_f, sum_f} == '0);
    endfunction

    function automatic bit outs_data();
        return &({cout_t, sum_t} | {cout_f, sum_f});
    endfunction

    task automatic drive_a(input logic [W-1:0] v);
        a_t = v; a_f = ~v;
    endtask

    task automatic drive_bc(input logic [W-1:0] v, input logic c);
        b_t = v; b_f = ~v; cin_t = c; cin_f = ~c;
    endtask

    task automatic drive_null();
        a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
    endtask

    // Wait at negedges until done equals lvl; returns edges counted.
    task automatic wait_done(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (done !== lvl && n < 40);
    endtask

    // Driver: push expectation, apply DATA, then NULL spacer.
    task automatic run_word(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic c, output int rise_n, output int fall_n);
        exp_q.push_back({1'b0, a} + {1'b0, b} + {{W{1'b0}}, c});
        drive_a(a);
        drive_bc(b, c);
        wait_done(1'b1, rise_n);
        check(outs_data(), "R5", "outputs all DATA when done seen", int'(outs_data()), 1);
        drive_null();
        wait_done(1'b0, fall_n);
        check(outs_null(), "R8", "outputs all NULL when done falls", int'({sum_t, sum_f}), 0);
        check(fall_n <= W + 2, "R8", "NULL return edges", fall_n, W + 2);
    endtask

    // Monitor: pop and compare on each rising completion; flag illegal pairs.
    logic last_done = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (((sum_t & sum_f) != '0) || (cout_t && cout_f))
                    check(1'b0, "R3", "illegal pair both rails high",
                          int'({cout_t & cout_f, sum_t & sum_f}), 0);
                if (done && !last_done) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "completion with no expected word", 1, 0);
                    end else begin
                        logic [W:0] e;
                        e = exp_q.pop_front();
                        check({cout_t, sum_t} == e, "R2", "sum/cout value",
                              int'({cout_t, sum_t}), int'(e));
                        check({cout_f, sum_f} == ~e, "R1", "false rails mirror value",
                              int'({cout_f, sum_f}), int'(~e));
                    end
                end
                last_done = done;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rn, fn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(outs_null(), "R1", "outputs NULL after reset", int'({sum_t, sum_f}), 0);
        check(done == 1'b0, "R1", "done low after reset", int'(done), 0);

        // R6: fastest word
        run_word(4'd0, 4'd0, 1'b0, rn, fn);
        check(rn == 3, "R6", "0+0 completion edges", rn, 3);

        // R7 / R8: slowest word
        run_word(4'd15, 4'd1, 1'b0, rn, fn);
        check(rn == W + 2, "R7", "15+1 completion edges", rn, W + 2);
        check(fn == W + 2, "R8", "15+1 NULL return edges", fn, W + 2);

        // R4: partial DATA below every threshold fires nothing
        drive_a(4'b1011);
        repeat (8) @(negedge clk);
        check(outs_null(), "R4", "partial DATA leaves outputs NULL",
              int'({sum_t, sum_f}), 0);
        check(done == 1'b0, "R4", "partial DATA leaves done low", int'(done), 0);
        exp_q.push_back(5'd11 + 5'd6 + 5'd1);
        drive_bc(4'd6, 1'b1);
        wait_done(1'b1, rn);
        check(rn <= W + 2, "R5", "completion after late operands", rn, W + 2);

        // R4: partial NULL holds outputs
        a_t = '0; a_f = '0;
        repeat (8) @(negedge clk);
        check({cout_t, sum_t} == 5'd18, "R4", "partial NULL keeps sum",
              int'({cout_t, sum_t}), 18);
        check(done == 1'b1, "R4", "partial NULL keeps done", int'(done), 1);
        drive_null();
        wait_done(1'b0, fn);
        check(outs_null(), "R8", "outputs NULL after full spacer", int'({sum_t, sum_f}), 0);

        // R2/R3/R5: exhaustive sweep
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_word(a[W-1:0], b[W-1:0], c[0], rn, fn);

        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all expected words consumed", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule